// File: doc/BRIEF.md
# Two-Channel PWM Timer

A 16-bit up-counter, advanced by a power-of-two prescaled enable taken from the bus clock, drives two edge-aligned PWM channels. Both channels share one modulo register, so they share one period of modulo+1 counts. Each channel compares the count with its own value register to form an active window at the start of every period. The window drives a pin whose polarity is chosen per channel. A counter rollover sets an overflow flag, and the end of each channel's active window sets that channel's flag. Each flag has its own interrupt enable and its own request output.

Software reaches the block through a small register port: a 4-bit address, write and read strobes, 16-bit write data and a combinational read-data output. A write to a duty port loads a channel value directly from a fraction. The written value is a full-scale bit plus an 8-bit fraction, and it is scaled by the current period with rounding. This spares software the 16×8 multiply.

Register addresses: 0 timer control, 1 count, 2 modulo, 3 channel 0 control, 4 channel 0 value, 5 channel 1 control, 6 channel 1 value, 7 channel 0 duty, 8 channel 1 duty. Timer control holds clock select in [1:0], prescale in [4:2], overflow interrupt enable in [5] and the overflow flag in [7]. Channel control holds mode in [1:0], edge select in [3:2], interrupt enable in [4] and the channel flag in [7]. The duty ports take the full-scale bit in [8] and the fraction in [7:0], and they read as 0.

Top module: `pwm_timer2`

## Requirements
- R1: With clock select (control [1:0]) = 01, the counter advances once every 2^PS bus cycles, where PS is control [4:2]. Any other clock select value holds the count. The prescale phase restarts when the count register is written.
- R2: The count runs 0,1,...,modulo and then returns to 0, giving a period of modulo+1 counts. The modulo resets to 0xFFFF.
- R3: Any write to address 1 sets the count to 0 on that clock, whatever data is written. The write takes priority over a coincident advance. Reading address 1 returns the current count.
- R4: The overflow flag (control [7]) is set on the advance from modulo to 0. ovf_irq_o equals the flag AND the enable in control [5].
- R5: A flag is cleared only by a write of 0 to its bit that follows a read of that register which returned the flag as 1. A clear write with no such read, or a write of 1, leaves the flag unchanged. A flag set in the same clock as a clear write stays set.
- R6: With mode 10 the channel is active while count < value. Edge select 10 drives the pin high while active. Edge select 01 drives the pin low while active. The pin goes inactive on the clock in which the count reaches the value.
- R7: A channel value greater than the modulo keeps the pin at its active level for the whole period. A value of 0 keeps it at its inactive level.
- R8: A mode other than 10 disables the channel. The pin is then held at its inactive level: 1 for edge select 01, and 0 otherwise.
- R9: The channel flag (channel control [7]) is set on the advance in which the count becomes equal to the value, when 0 < value ≤ modulo and mode is 10. ch_irq_o[n] equals the flag AND the enable in channel control [4].
- R10: A duty write with bit [8] = 0 loads the channel value with round(X·(modulo+1)/256), where X = bits [7:0]. The round-up is taken from the most significant discarded fraction bit.
- R11: A duty write with bit [8] = 1 loads the channel value with 0xFFFF, whatever the fraction is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; arms flag clearing |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| pwm_o | output | 2 | Channel pins |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| ch_irq_o | output | 2 | Channel interrupt requests |

## Verification
Two functions can land on the same clock: the flag-set logic on a counter rollover, and a software clear write that has been armed by an earlier read of the flag. The bench waits until the count is one below the modulo and arms the clear with a read, which lets the count reach the modulo. It then issues the clear write so that it lands exactly on the rollover edge. The flag and ovf_irq_o are expected to stay set. A second clear, made with the timer stopped, must then take effect.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int ADDR_W   = 4;
  localparam int FLAG_BIT = 7;
  localparam int CH_BASE  = 3;
  localparam logic [1:0] CLK_BUS  = 2'b01;
  localparam logic [1:0] MODE_PWM = 2'b10;
  localparam logic [1:0] EDGE_POS = 2'b10;
  localparam logic [1:0] EDGE_NEG = 2'b01;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MOD  = 4'd2;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int PDW = (1 << PS_W) - 1;

  logic [PDW-1:0] div_q;
  logic [PDW:0]   sh;
  logic [PDW-1:0] mask;

  assign sh     = {{PDW{1'b0}}, 1'b1} << ps_i;
  assign mask   = sh[PDW-1:0] - {{(PDW-1){1'b0}}, 1'b1};
  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (run_i)     div_q <= div_q + 1'b1;
  end

  a_r1_idle_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         adv_o,
  output logic         wrap_o
);
  logic at_top;

  assign at_top = (cnt_o == mod_i);
  assign nxt_o  = at_top ? '0 : cnt_o + 1'b1;
  assign adv_o  = tick_i && !clr_i;
  assign wrap_o = adv_o && at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (adv_o) cnt_o <= nxt_o;
  end

  a_r3_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  a_r2_wraps_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && cnt_o == mod_i) |=> (cnt_o == '0));
  a_r1_holds_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pwmt_flag.sv
module pwmt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      if (wr_i)                armed_q <= 1'b0;
      else if (rd_i && flag_o) armed_q <= 1'b1;
      if (set_i)                           flag_o <= 1'b1;
      else if (wr_i && !wbit_i && armed_q) flag_o <= 1'b0;
    end
  end

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r5_only_zero_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !(wr_i && !wbit_i)) |=> flag_o);
  a_r5_only_set_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/pwmt_duty.sv
module pwmt_duty #(
  parameter int W      = 16,
  parameter int FRAC_W = 8
) (
  input  logic              full_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [W-1:0]      mod_i,
  output logic [W-1:0]      val_o
);
  localparam int PW = W + 1;
  localparam int XW = PW + FRAC_W;

  logic [PW-1:0] period;
  logic [XW-1:0] prod;
  logic [PW-1:0] scaled;

  assign period = {1'b0, mod_i} + {{W{1'b0}}, 1'b1};
  assign prod   = {{PW{1'b0}}, frac_i} * {{FRAC_W{1'b0}}, period};
  assign scaled = prod[XW-1:FRAC_W] + {{(PW-1){1'b0}}, prod[FRAC_W-1]};
  assign val_o  = full_i ? '1 : scaled[W-1:0];
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_ctrl_i,
  input  logic         rd_ctrl_i,
  input  logic         wr_val_i,
  input  logic         load_duty_i,
  input  logic [W-1:0] duty_val_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] nxt_i,
  input  logic         adv_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] ctrl_rd_o,
  output logic [W-1:0] val_o,
  output logic         pin_o,
  output logic         irq_o
);
  logic [1:0] mode_q, edge_q;
  logic       ie_q, en, pol_neg, active, in_range, end_hit, flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      edge_q <= '0;
      ie_q   <= 1'b0;
      val_o  <= '0;
    end else begin
      if (wr_ctrl_i) begin
        mode_q <= wdata_i[1:0];
        edge_q <= wdata_i[3:2];
        ie_q   <= wdata_i[4];
      end
      if (wr_val_i)         val_o <= wdata_i;
      else if (load_duty_i) val_o <= duty_val_i;
    end
  end

  assign en       = (mode_q == MODE_PWM);
  assign pol_neg  = (edge_q == EDGE_NEG);
  assign active   = (cnt_i < val_o);
  assign pin_o    = pol_neg ^ (en && active);
  assign in_range = (val_o != '0) && (val_o <= mod_i);
  assign end_hit  = adv_i && en && in_range && (nxt_i == val_o);

  pwmt_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (end_hit),
    .rd_i   (rd_ctrl_i),
    .wr_i   (wr_ctrl_i),
    .wbit_i (wdata_i[FLAG_BIT]),
    .flag_o (flag)
  );

  assign irq_o = flag && ie_q;

  always_comb begin
    ctrl_rd_o           = '0;
    ctrl_rd_o[1:0]      = mode_q;
    ctrl_rd_o[3:2]      = edge_q;
    ctrl_rd_o[4]        = ie_q;
    ctrl_rd_o[FLAG_BIT] = flag;
  end

  a_r8_disabled_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (pin_o == pol_neg));
  a_r7_over_modulo_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && val_o > mod_i && cnt_i <= mod_i) |-> (pin_o != pol_neg));
  a_r6_inactive_at_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == val_o) |-> (pin_o == pol_neg));
  a_r9_flag_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && en && val_o != '0 && val_o <= mod_i && nxt_i == val_o) |=> ctrl_rd_o[FLAG_BIT]);
endmodule

// File: rtl/pwm_timer2.sv
module pwm_timer2
  import pwmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int NCH    = 2,
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NCH-1:0]    pwm_o,
  output logic              ovf_irq_o,
  output logic [NCH-1:0]    ch_irq_o
);
  localparam int IE_B = 2 + PS_W;

  logic [1:0]       clk_sel_q;
  logic [PS_W-1:0]  ps_q;
  logic             ovf_ie_q, ovf_flag;
  logic [CNT_W-1:0] mod_q, cnt, nxt, duty_val;
  logic             run, tick, adv, wrap, cnt_clr, hit_ctrl;
  logic [NCH-1:0]   hit_cc, hit_cv, hit_dt;
  logic [CNT_W-1:0] ch_ctrl [NCH];
  logic [CNT_W-1:0] ch_val  [NCH];

  assign hit_ctrl = (addr_i == A_CTRL);
  assign cnt_clr  = wr_i && (addr_i == A_CNT);
  assign run      = (clk_sel_q == CLK_BUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_q <= '0;
      ps_q      <= '0;
      ovf_ie_q  <= 1'b0;
      mod_q     <= '1;
    end else begin
      if (wr_i && hit_ctrl) begin
        clk_sel_q <= wdata_i[1:0];
        ps_q      <= wdata_i[2 +: PS_W];
        ovf_ie_q  <= wdata_i[IE_B];
      end
      if (wr_i && addr_i == A_MOD) mod_q <= wdata_i;
    end
  end

  pwmt_prescaler #(.PS_W(PS_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (cnt_clr),
    .ps_i      (ps_q),
    .tick_o    (tick)
  );

  pwmt_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clr_i  (cnt_clr),
    .mod_i  (mod_q),
    .cnt_o  (cnt),
    .nxt_o  (nxt),
    .adv_o  (adv),
    .wrap_o (wrap)
  );

  pwmt_flag u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wrap),
    .rd_i   (rd_i && hit_ctrl),
    .wr_i   (wr_i && hit_ctrl),
    .wbit_i (wdata_i[FLAG_BIT]),
    .flag_o (ovf_flag)
  );

  assign ovf_irq_o = ovf_flag && ovf_ie_q;

  pwmt_duty #(.W(CNT_W), .FRAC_W(FRAC_W)) u_duty (
    .full_i (wdata_i[FRAC_W]),
    .frac_i (wdata_i[FRAC_W-1:0]),
    .mod_i  (mod_q),
    .val_o  (duty_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CC = ADDR_W'(CH_BASE + 2 * i);
    localparam logic [ADDR_W-1:0] A_CV = ADDR_W'(CH_BASE + 2 * i + 1);
    localparam logic [ADDR_W-1:0] A_DT = ADDR_W'(CH_BASE + 2 * NCH + i);

    assign hit_cc[i] = (addr_i == A_CC);
    assign hit_cv[i] = (addr_i == A_CV);
    assign hit_dt[i] = (addr_i == A_DT);

    pwmt_channel #(.W(CNT_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_ctrl_i   (wr_i && hit_cc[i]),
      .rd_ctrl_i   (rd_i && hit_cc[i]),
      .wr_val_i    (wr_i && hit_cv[i]),
      .load_duty_i (wr_i && hit_dt[i]),
      .duty_val_i  (duty_val),
      .wdata_i     (wdata_i),
      .cnt_i       (cnt),
      .nxt_i       (nxt),
      .adv_i       (adv),
      .mod_i       (mod_q),
      .ctrl_rd_o   (ch_ctrl[i]),
      .val_o       (ch_val[i]),
      .pin_o       (pwm_o[i]),
      .irq_o       (ch_irq_o[i])
    );

    a_r11_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && hit_dt[i] && wdata_i[FRAC_W]) |=> (ch_val[i] == '1));
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[1:0]      = clk_sel_q;
      rdata_o[2 +: PS_W] = ps_q;
      rdata_o[IE_B]     = ovf_ie_q;
      rdata_o[FLAG_BIT] = ovf_flag;
    end
    if (addr_i == A_CNT) rdata_o = cnt;
    if (addr_i == A_MOD) rdata_o = mod_q;
    for (int i = 0; i < NCH; i++) begin
      if (hit_cc[i]) rdata_o = ch_ctrl[i];
      if (hit_cv[i]) rdata_o = ch_val[i];
    end
  end

  a_r4_flag_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_flag);
  a_r4_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> (ovf_ie_q && ovf_flag));
  a_r1_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_clr) |=> $stable(cnt));
endmodule

// File: tb/pwm_timer2_bench.sv
module pwm_timer2_bench;
  localparam int TCLK = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  pwm, ch_irq;
  logic        ovf_irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #(TCLK/2) clk = ~clk;

  pwm_timer2 u_pwm_timer2 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr_en), .rd_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .ovf_irq_o(ovf_irq), .ch_irq_o(ch_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1; #1;
    d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    peek(1, d); chk("R2 reset count", d, 0);
    peek(2, d); chk("R2 reset modulo", d, 16'hFFFF);
    peek(0, d); chk("R4 reset control", d, 0);
    chk("R8 reset pins", pwm, 0);
    chk("R4 reset irqs", {ovf_irq, ch_irq}, 0);
  endtask

  task automatic t_count();
    logic [15:0] d;
    wr(2, 4); wr(0, 16'h0001); wr(1, 16'hABCD);
    for (int n = 0; n < 12; n++) begin
      peek(1, d); chk("R2/R3 count sequence", d, n % 5);
      step();
    end
    peek(0, d); chk("R4 ovf flag after wrap", d[7], 1);
    chk("R4 irq masked", ovf_irq, 0);
  endtask

  task automatic t_presc();
    logic [15:0] d, a;
    wr(0, 16'h0009); wr(1, 0);
    for (int n = 0; n < 12; n++) begin
      peek(1, d); chk("R1 prescale by 4", d, n / 4);
      step();
    end
    wr(0, 16'h0000);
    peek(1, a);
    repeat (6) step();
    peek(1, d); chk("R1 stopped holds", d, a);
  endtask

  task automatic t_pwm();
    wr(0, 0); wr(2, 4);
    wr(4, 2); wr(3, 16'h000A);
    wr(6, 3); wr(5, 16'h0006);
    wr(1, 0); wr(0, 16'h0001);
    for (int n = 0; n < 10; n++) begin
      chk("R6 positive polarity", pwm[0], ((n % 5) < 2));
      chk("R6 negative polarity", pwm[1], !((n % 5) < 3));
      step();
    end
  endtask

  task automatic t_full();
    wr(4, 5); wr(6, 0);
    for (int n = 0; n < 6; n++) begin
      chk("R7 value above modulo full", pwm[0], 1);
      chk("R7 value zero inactive", pwm[1], 1);
      step();
    end
  endtask

  task automatic t_off();
    wr(4, 2); wr(6, 2);
    wr(3, 16'h0008); wr(5, 16'h0004);
    for (int n = 0; n < 6; n++) begin
      chk("R8 disabled pos low", pwm[0], 0);
      chk("R8 disabled neg high", pwm[1], 1);
      step();
    end
  endtask

  task automatic t_chflag();
    logic [15:0] d;
    wr(0, 0); wr(4, 2); wr(3, 16'h001A);
    rd(3, d); wr(3, 16'h001A);
    peek(3, d); chk("R5 armed clear", d[7], 0);
    chk("R9 irq low after clear", ch_irq[0], 0);
    wr(1, 0); wr(0, 16'h0001);
    peek(3, d); chk("R9 flag before end n0", d[7], 0); step();
    peek(3, d); chk("R9 flag before end n1", d[7], 0); step();
    peek(3, d); chk("R9 flag at value", d[7], 1);
    chk("R9 channel irq", ch_irq[0], 1);
    wr(0, 0);
    wr(3, 16'h001A);
    peek(3, d); chk("R5 unarmed clear ignored", d[7], 1);
    rd(3, d); wr(3, 16'h001A);
    peek(3, d); chk("R5 armed clear works", d[7], 0);
    wr(3, 16'h009A);
    peek(3, d); chk("R5 write one no effect", d[7], 0);
  endtask

  task automatic t_ovf();
    logic [15:0] d;
    int guard;
    wr(0, 0); wr(1, 0);
    rd(0, d); wr(0, 16'h0000);
    peek(0, d); chk("R5 ovf cleared", d[7], 0);
    wr(0, 16'h0021);
    for (int n = 0; n < 5; n++) begin
      peek(0, d); chk("R4 no ovf before wrap", d[7], 0); step();
    end
    peek(0, d); chk("R4 ovf on wrap", d[7], 1);
    chk("R4 ovf irq enabled", ovf_irq, 1);
    guard = 0;
    peek(1, d);
    while (d != 3 && guard < 20) begin step(); peek(1, d); guard++; end
    rd(0, d);
    peek(1, d); chk("R5 setup count at modulo", d, 4);
    wr(0, 16'h0021);
    peek(0, d); chk("R5 set beats coincident clear", d[7], 1);
    chk("R4 irq stays", ovf_irq, 1);
    wr(0, 16'h0020);
    rd(0, d); wr(0, 16'h0020);
    peek(0, d); chk("R5 clear when stopped", d[7], 0);
    chk("R4 irq drops", ovf_irq, 0);
  endtask

  task automatic t_duty();
    logic [15:0] d;
    wr(0, 0); wr(2, 999);
    wr(7, 16'h0080); peek(4, d); chk("R10 half of 1000", d, 500);
    wr(7, 16'h0040); peek(4, d); chk("R10 quarter of 1000", d, 250);
    wr(7, 16'h0001); peek(4, d); chk("R10 rounding up", d, 4);
    wr(7, 16'h0000); peek(4, d); chk("R10 zero fraction", d, 0);
    wr(8, 16'h0155); peek(6, d); chk("R11 full scale", d, 16'hFFFF);
    wr(2, 16'hFFFF);
    wr(7, 16'h00FF); peek(4, d); chk("R10 max period", d, 16'hFF00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    t_reset();
    t_count();
    t_presc();
    t_pwm();
    t_full();
    t_off();
    t_chflag();
    t_ovf();
    t_duty();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule